// File: doc/BRIEF.md
# Priority Interrupt Controller with Claim and Complete

This block collects interrupt requests from `NUM_SRC` sources for one processor context and raises a single interrupt line when at least one source should be serviced. A rising edge on a source's request input records that source as pending. Each source has an enable bit and a 3-bit priority, and there is one 3-bit threshold for the context. A source competes for service only if it is pending, enabled, and has a priority strictly above the threshold. The winner is the competing source with the highest priority. When two competitors have the same priority, the lower source ID wins.

Software services the interrupt through one claim/complete register. Reading that register returns the winning source ID, clears that source's pending bit, and marks the source as in service. While a source is in service, new request edges on it are dropped. Writing the source's ID back to the same register ends the service period. After that, a new request edge on the source can make it pending again. Source ID 0 is reserved and means "no interrupt".

The register port is a simple single-cycle valid/write/address/data interface with word addressing. Read data is combinational in the cycle the request is valid. Side effects of a claim read take effect at the next clock edge.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt output is low. Every pending, in-service, enable and priority bit is zero, and the threshold (word 0x00) is zero.
- R2: A 0-to-1 transition on `src_req_i[s-1]` sets the pending bit of source s. Pending state is read from word 0x08 + s/32, with source s at bit s%32. The bit is visible at the clock edge that samples the transition.
- R3: Priority word 0x10 + k holds the priority of source k+1. A write keeps only bits [2:0], and a read returns those 3 bits zero-extended.
- R4: Enable words start at word 0x04, with source s at bit s%32 of word 0x04 + s/32. A source is eligible only if it is pending, enabled, and its priority is strictly greater than the threshold.
- R5: Among eligible sources, the highest priority wins. On equal priority, the lowest source ID wins.
- R6: `irq_o` is registered. It goes high or low one clock edge after the state change that makes an eligible winner appear or disappear.
- R7: A read of the claim/complete word 0x01 returns the current winner ID. At the next edge the read clears that source's pending bit and marks the source in service, and `irq_o` is re-evaluated one edge later.
- R8: A claim read while no source is eligible returns 0 and changes no pending or in-service state.
- R9: A request edge on a source that is in service does not set its pending bit.
- R10: Writing source ID s to word 0x01 ends service of s. A later request edge on s sets its pending bit again.
- R11: A completion write of 0, or of any value above `NUM_SRC`, changes no state. An in-service source stays in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NUM_SRC | Request lines; bit s-1 belongs to source s |
| reg_req_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench targets three corner cases:

- **Ties and strict comparison.** If a tie is broken toward the higher ID, or if the threshold comparison uses greater-or-equal, the design returns the wrong claim ID. A source whose priority equals the threshold would also raise the interrupt line.
- **The in-service window.** The bench fires request edges on a claimed source before completion, after completions with ID 0 and with an out-of-range ID, and after the proper completion. A design that forgets the in-service bit, or that matches the ID only in its low bits, shows a pending bit where none is expected.
- **Edge-exact timing.** The bench samples `irq_o` both in the cycle before and the cycle after it must change. It also issues a claim read with nothing eligible, which catches a design that clears source 0 or some other source by mistake.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned WORD_W = 32;

  // Word addresses of the register port
  localparam int unsigned ADR_THRESH    = 'h00;
  localparam int unsigned ADR_CLAIM     = 'h01;
  localparam int unsigned ADR_EN_BASE   = 'h04;
  localparam int unsigned ADR_PEND_BASE = 'h08;
  localparam int unsigned ADR_PRIO_BASE = 'h10;

  function automatic int unsigned vec_words(input int unsigned nsrc);
    return (nsrc + WORD_W) / WORD_W;
  endfunction
endpackage

// File: rtl/prio_intc_srcstate.sv
module prio_intc_srcstate
  import prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ID_W    = $clog2(NUM_SRC + 1),
  parameter int unsigned VEC_W   = vec_words(NUM_SRC) * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               claim_fire_i,
  input  logic [ID_W-1:0]    claim_id_i,
  input  logic               cmpl_fire_i,
  input  logic [WORD_W-1:0]  cmpl_id_i,
  output logic [VEC_W-1:0]   pend_o
);

  logic [VEC_W-1:0] pend_q;
  logic [VEC_W-1:0] busy_q;

  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    if (b >= 1 && b <= NUM_SRC) begin : g_src
      logic req_q;
      logic rise, hit_claim, hit_cmpl;
      logic pend_d, busy_d, pend_en, busy_en;

      always_comb begin
        rise      = src_req_i[b-1] & ~req_q;
        hit_claim = claim_fire_i && (claim_id_i == ID_W'(b));
        hit_cmpl  = cmpl_fire_i && (cmpl_id_i == WORD_W'(b));
        pend_en   = hit_claim | (rise & ~busy_q[b]);
        pend_d    = ~hit_claim;
        busy_en   = hit_claim | hit_cmpl;
        busy_d    = hit_claim;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= src_req_i[b-1];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pend_q[b] <= 1'b0;
        else if (pend_en) pend_q[b] <= pend_d;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      busy_q[b] <= 1'b0;
        else if (busy_en) busy_q[b] <= busy_d;
      end

      AST_CLAIM_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_claim |=> (busy_q[b] && !pend_q[b])); // R7
      AST_CMPL_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_cmpl && !hit_claim) |=> !busy_q[b]); // R10
      AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_q[b] && !hit_cmpl) |=> !pend_q[b]); // R9
    end else begin : g_none
      assign pend_q[b] = 1'b0;
      assign busy_q[b] = 1'b0;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/prio_intc_cfg.sv
module prio_intc_cfg
  import prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NWORD   = vec_words(NUM_SRC),
  parameter int unsigned VEC_W   = NWORD * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [PRIO_W-1:0] thr_o,
  output logic [VEC_W-1:0]  en_o,
  output logic [PRIO_W-1:0] prio_o [NUM_SRC+1]
);

  // Threshold
  logic              thr_we;
  logic [PRIO_W-1:0] thr_q;

  assign thr_we = wr_i && (int'(addr_i) == ADR_THRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     thr_q <= '0;
    else if (thr_we) thr_q <= wdata_i[PRIO_W-1:0];
  end
  assign thr_o = thr_q;

  // Enable words, one flop per real source bit
  for (genvar w = 0; w < NWORD; w++) begin : g_enw
    logic en_we;
    assign en_we = wr_i && (int'(addr_i) == ADR_EN_BASE + w);
    for (genvar i = 0; i < WORD_W; i++) begin : g_enb
      localparam int unsigned SID = w * WORD_W + i;
      if (SID >= 1 && SID <= NUM_SRC) begin : g_real
        logic en_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)    en_q <= 1'b0;
          else if (en_we) en_q <= wdata_i[i];
        end
        assign en_o[SID] = en_q;
      end else begin : g_tie
        assign en_o[SID] = 1'b0;
      end
    end
  end

  // Priorities: word ADR_PRIO_BASE + k belongs to source k + 1
  assign prio_o[0] = '0;
  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_prio
    logic              prio_we;
    logic [PRIO_W-1:0] prio_q;
    assign prio_we = wr_i && (int'(addr_i) == ADR_PRIO_BASE + s - 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      prio_q <= '0;
      else if (prio_we) prio_q <= wdata_i[PRIO_W-1:0];
    end
    assign prio_o[s] = prio_q;

    AST_PRIO_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prio_we |=> (prio_o[s] == $past(wdata_i[PRIO_W-1:0]))); // R3
  end

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = $clog2(NUM_SRC + 1),
  parameter int unsigned VEC_W   = vec_words(NUM_SRC) * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VEC_W-1:0]  pend_i,
  input  logic [VEC_W-1:0]  en_i,
  input  logic [PRIO_W-1:0] prio_i [NUM_SRC+1],
  input  logic [PRIO_W-1:0] thr_i,
  output logic [ID_W-1:0]   win_id_o,
  output logic              win_valid_o
);

  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   best_id;

  // Scan upward; a later source replaces the leader only when strictly
  // higher, so the lowest ID keeps a tie.
  always_comb begin
    best_prio = thr_i;
    best_id   = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pend_i[s] && en_i[s] && (prio_i[s] > best_prio)) begin
        best_prio = prio_i[s];
        best_id   = ID_W'(s);
      end
    end
  end

  assign win_id_o    = best_id;
  assign win_valid_o = (best_id != '0);

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (pend_i[win_id_o] && en_i[win_id_o]
                     && (prio_i[win_id_o] > thr_i))); // R4
  AST_WINNER_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_id_o <= ID_W'(NUM_SRC)); // R5

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);

  localparam int unsigned NWORD = vec_words(NUM_SRC);
  localparam int unsigned VEC_W = NWORD * WORD_W;
  localparam int unsigned ID_W  = $clog2(NUM_SRC + 1);

  logic              wr, rd, claim_fire, cmpl_fire;
  logic [PRIO_W-1:0] thr;
  logic [VEC_W-1:0]  en, pend;
  logic [PRIO_W-1:0] prio [NUM_SRC+1];
  logic [ID_W-1:0]   win_id;
  logic              win_valid;
  logic              irq_q;

  assign wr         = reg_req_i & reg_we_i;
  assign rd         = reg_req_i & ~reg_we_i;
  assign claim_fire = rd && (int'(reg_addr_i) == ADR_CLAIM) && win_valid;
  assign cmpl_fire  = wr && (int'(reg_addr_i) == ADR_CLAIM);

  prio_intc_cfg #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .thr_o   (thr),
    .en_o    (en),
    .prio_o  (prio)
  );

  prio_intc_srcstate #(
    .NUM_SRC (NUM_SRC)
  ) u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_req_i    (src_req_i),
    .claim_fire_i (claim_fire),
    .claim_id_i   (win_id),
    .cmpl_fire_i  (cmpl_fire),
    .cmpl_id_i    (reg_wdata_i),
    .pend_o       (pend)
  );

  prio_intc_arb #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
  ) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend),
    .en_i        (en),
    .prio_i      (prio),
    .thr_i       (thr),
    .win_id_o    (win_id),
    .win_valid_o (win_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= win_valid;
  end
  assign irq_o = irq_q;

  // Read mux
  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      if (int'(reg_addr_i) == ADR_THRESH) reg_rdata_o[PRIO_W-1:0] = thr;
      if (int'(reg_addr_i) == ADR_CLAIM)  reg_rdata_o[ID_W-1:0]   = win_id;
      for (int w = 0; w < NWORD; w++) begin
        if (int'(reg_addr_i) == ADR_EN_BASE + w)
          reg_rdata_o = en[w*WORD_W +: WORD_W];
        if (int'(reg_addr_i) == ADR_PEND_BASE + w)
          reg_rdata_o = pend[w*WORD_W +: WORD_W];
      end
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (int'(reg_addr_i) == ADR_PRIO_BASE + s - 1)
          reg_rdata_o[PRIO_W-1:0] = prio[s];
      end
    end
  end

  AST_EMPTY_CLAIM_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (int'(reg_addr_i) == ADR_CLAIM) && !win_valid && !wr
     && (src_req_i == '0)) |=> $stable(pend)); // R8
  AST_CLAIM_DROPS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_fire |=> !pend[$past(win_id)]); // R7

endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         r_req, r_we;
  logic [7:0]   r_addr;
  logic [31:0]  r_wdata;
  logic [31:0]  r_rdata;
  logic         irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  prio_intc #(.NUM_SRC(N), .PRIO_W(3), .ADDR_W(8)) u_prio_intc (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_req_i   (req),
    .reg_req_i   (r_req),
    .reg_we_i    (r_we),
    .reg_addr_i  (r_addr),
    .reg_wdata_i (r_wdata),
    .reg_rdata_o (r_rdata),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    req = '0; r_req = 0; r_we = 0; r_addr = '0; r_wdata = '0;
    rst_n = 0;
    tick();
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    r_req = 1; r_we = 1; r_addr = a; r_wdata = d;
    tick();
    r_req = 0; r_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    r_req = 1; r_we = 0; r_addr = a;
    #2 d = r_rdata;
    tick();
    r_req = 0;
  endtask

  task automatic pulse(input int s);
    req[s-1] = 1'b1;
    tick();
    req[s-1] = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 irq after reset", {31'd0, irq}, 0);
    rd(8'h00, d); check("R1 threshold", d, 0);
    rd(8'h08, d); check("R1 pending word", d, 0);
    rd(8'h04, d); check("R1 enable word", d, 0);
    rd(8'h12, d); check("R1 priority of source 3", d, 0);
    rd(8'h01, d); check("R1 claim after reset", d, 0);
  endtask

  task automatic t_prio_and_threshold();
    logic [31:0] d;
    do_reset();
    wr(8'h12, 32'hFFFF_FFFD);
    rd(8'h12, d); check("R3 priority keeps low 3 bits", d, 5);
    rd(8'h11, d); check("R3 neighbour priority untouched", d, 0);
    pulse(3);
    rd(8'h08, d); check("R2 pending bit 3", d, 32'h8);
    check("R4 disabled source no irq", {31'd0, irq}, 0);
    wr(8'h00, 5);
    wr(8'h04, 32'h8);
    tick();
    check("R4 priority equal to threshold no irq", {31'd0, irq}, 0);
    wr(8'h00, 4);
    check("R6 irq still low right after write", {31'd0, irq}, 0);
    tick();
    check("R6 irq high one edge later", {31'd0, irq}, 1);
    wr(8'h04, 32'h0);
    check("R6 irq still high right after disable", {31'd0, irq}, 1);
    tick();
    check("R4 irq low after disable", {31'd0, irq}, 0);
  endtask

  task automatic t_arbitrate();
    logic [31:0] d;
    do_reset();
    wr(8'h11, 6);   // source 2
    wr(8'h14, 6);   // source 5
    wr(8'h16, 7);   // source 7
    wr(8'h04, 32'hA4);
    pulse(5); pulse(2); pulse(7);
    rd(8'h08, d); check("R2 three pending bits", d, 32'hA4);
    check("R6 irq with winners", {31'd0, irq}, 1);
    rd(8'h01, d); check("R5 highest priority first", d, 7);
    rd(8'h01, d); check("R5 tie goes to lower ID", d, 2);
    rd(8'h08, d); check("R7 claimed bits cleared", d, 32'h20);
    rd(8'h01, d); check("R7 last claim", d, 5);
    check("R7 irq still high right after final claim", {31'd0, irq}, 1);
    tick();
    check("R7 irq low after final claim", {31'd0, irq}, 0);
    rd(8'h01, d); check("R8 empty claim reads 0", d, 0);
  endtask

  task automatic t_empty_claim();
    logic [31:0] d;
    do_reset();
    wr(8'h13, 2);
    pulse(4);
    rd(8'h01, d); check("R8 claim with source disabled", d, 0);
    rd(8'h08, d); check("R8 pending unchanged", d, 32'h10);
    wr(8'h04, 32'h10);
    rd(8'h01, d); check("R8 source claimable afterwards", d, 4);
  endtask

  task automatic t_service_window();
    logic [31:0] d;
    do_reset();
    wr(8'h13, 3);
    wr(8'h04, 32'h10);
    pulse(4);
    rd(8'h01, d); check("R7 claim source 4", d, 4);
    pulse(4);
    rd(8'h08, d); check("R9 edge while in service ignored", d, 0);
    check("R9 irq stays low", {31'd0, irq}, 0);
    wr(8'h01, 0);
    wr(8'h01, 9);
    wr(8'h01, 32'h0000_0104);
    pulse(4);
    rd(8'h08, d); check("R11 bad completions ignored", d, 0);
    wr(8'h01, 4);
    pulse(4);
    rd(8'h08, d); check("R10 pending again after completion", d, 32'h10);
    rd(8'h01, d); check("R10 claim after completion", d, 4);
  endtask

  initial begin
    t_reset();
    t_prio_and_threshold();
    t_arbitrate();
    t_empty_claim();
    t_service_window();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule